// File: doc/BRIEF.md
# Store Drain Queue

This block holds stores after they have executed and before they have left for the data cache. Stores enter at the tail in program order, and each carries an address, data, a byte size and a sequence number. When retirement reports the youngest retired sequence number, every held store at or below it becomes eligible to write back. A writeback pointer then walks the eligible stores oldest first and offers each one to a cache request port. A store with zero size never goes to the cache and is finished on the spot.

The cache may refuse an offer. In that case the queue parks on that store and stays silent until the cache raises its retry line, then offers the same store again. Completion acknowledgements name a slot and may come in any order. A slot is released only when it and every slot older than it have completed. A pipeline flush gives a sequence number, and every younger store that has not yet become eligible is dropped from the tail end.

The storage has one spare slot, so a queue of DEPTH usable entries uses indices 0 to DEPTH, wrapping modulo DEPTH+1.

Top module: `store_wb_queue`

## Requirements
- R1: A store is accepted only when fewer than DEPTH entries are held, and `alloc_ready_o` shows this. An accepted store takes the slot shown on `alloc_idx_o`, and that index then steps by one modulo DEPTH+1. When the queue is full, a store offered is dropped and `count_o` does not rise.
- R2: A commit with sequence number C makes every held, not yet eligible store whose sequence number is at most C eligible in the next cycle. `await_o` rises by the number of stores newly made eligible.
- R3: Only eligible stores are offered, one per cycle, in allocation order. `req_idx_o`, `req_addr_o`, `req_data_o` and `req_size_o` describe the store at the writeback pointer. A store is taken when `req_valid_o` and `req_ready_i` are both high, and the pointer then moves on.
- R4: An eligible store of size 0 raises no request. It is marked complete in the cycle it reaches the writeback pointer, `await_o` falls by one and the pointer moves past it.
- R5: An offer refused by the cache (`req_ready_i` low) sets `blocked_o`. While blocked, `req_valid_o` follows `retry_i`, and the same slot is offered again. Only an accepted offer clears `blocked_o` and moves the pointer.
- R6: An acknowledgement naming a slot that was sent and not yet completed marks that slot complete and lowers `await_o` by one. An acknowledgement naming any other slot, or an index above DEPTH, has no effect.
- R7: Slots are freed from the head only across an unbroken run of completed entries. `count_o` gives the number of held stores, and a completion out of order frees nothing until the older stores complete.
- R8: A squash with sequence number S drops, from the youngest end, every store whose sequence number is greater than S, and stops at the first eligible store. A commit in the same cycle is applied before the squash. A store offered in a squash cycle is not accepted.
- R9: After reset the queue is empty: `count_o` and `await_o` are 0, `alloc_ready_o` is 1, `alloc_idx_o` is 0, and `blocked_o` and `req_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | New store offered |
| alloc_addr_i | input | AW | Store address |
| alloc_data_i | input | DW | Store data |
| alloc_size_i | input | ZW | Store size in bytes |
| alloc_seq_i | input | SW | Store sequence number |
| alloc_ready_o | output | 1 | Queue has room |
| alloc_idx_o | output | PW | Slot the next store takes |
| commit_valid_i | input | 1 | Commit pulse |
| commit_seq_i | input | SW | Youngest retired sequence number |
| squash_valid_i | input | 1 | Squash pulse |
| squash_seq_i | input | SW | Stores younger than this are dropped |
| req_valid_o | output | 1 | Cache write request |
| req_ready_i | input | 1 | Cache accepts the request |
| retry_i | input | 1 | Cache invites a resend after a refusal |
| req_idx_o | output | PW | Slot of the offered store |
| req_addr_o | output | AW | Address of the offered store |
| req_data_o | output | DW | Data of the offered store |
| req_size_o | output | ZW | Size of the offered store |
| ack_valid_i | input | 1 | Completion acknowledgement |
| ack_idx_i | input | PW | Slot being acknowledged |
| blocked_o | output | 1 | Waiting for a retry |
| count_o | output | CW | Stores held |
| await_o | output | CW | Eligible stores not yet complete |

## Verification
A directed opening fills the queue and offers one more store, then commits only part of it. It acknowledges the younger of two sent stores first, which shows that release waits for the oldest store. It then walks a zero-size store past the pointer, and takes one store through refusal, a silent cycle, a refused retry and an accepted retry. This separates the blocked path from the normal path. Acknowledgements to an unsent slot, and a squash that meets an eligible store with an allocation in the same cycle, show that neither can remove committed work. A long random phase then mixes all inputs across many pointer wraps, and a behavioural queue model is compared against every output on each cycle.

// File: rtl/store_wb_queue.sv
module store_wb_queue #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int ZW = 4,
  parameter int SW = 16,
  localparam int N = DEPTH + 1,
  localparam int PW = $clog2(N),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic [DW-1:0] alloc_data_i,
  input  logic [ZW-1:0] alloc_size_i,
  input  logic [SW-1:0] alloc_seq_i,
  output logic          alloc_ready_o,
  output logic [PW-1:0] alloc_idx_o,
  input  logic          commit_valid_i,
  input  logic [SW-1:0] commit_seq_i,
  input  logic          squash_valid_i,
  input  logic [SW-1:0] squash_seq_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  input  logic          retry_i,
  output logic [PW-1:0] req_idx_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_data_o,
  output logic [ZW-1:0] req_size_o,
  input  logic          ack_valid_i,
  input  logic [PW-1:0] ack_idx_i,
  output logic          blocked_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] await_o
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] v);
    return (v == PW'(N - 1)) ? '0 : v + 1'b1;
  endfunction

  logic [AW-1:0] addr_q [N];
  logic [DW-1:0] data_q [N];
  logic [ZW-1:0] size_q [N];
  logic [SW-1:0] seq_q  [N];
  logic [N-1:0]  vld_q, elg_q, snt_q, dne_q;
  logic [PW-1:0] head_q, tail_q, wb_q;
  logic          blk_q;
  logic [CW-1:0] await_q;

  logic          full, alloc_fire, wb_live, zero_fire, accept, ack_ok, ack_inrange;
  logic [N-1:0]  cmask, smask, fmask, amask, elg_c, done_n;
  logic [PW-1:0] head_n, tail_n, p;
  logic          go;
  logic [PW:0]   occ, tdiff;
  int            scnt, ccnt;

  assign full          = (nxt(tail_q) == head_q);
  assign alloc_ready_o = !full;
  assign alloc_idx_o   = tail_q;
  assign alloc_fire    = alloc_valid_i && !full && !squash_valid_i;
  assign amask         = alloc_fire ? (ONE << tail_q) : '0;

  assign occ     = ({1'b0, tail_q} >= {1'b0, head_q}) ? ({1'b0, tail_q} - {1'b0, head_q})
                                                      : ({1'b0, tail_q} + (PW+1)'(N) - {1'b0, head_q});
  assign count_o = CW'(occ);
  assign await_o = await_q;
  assign blocked_o = blk_q;

  assign wb_live     = (wb_q != tail_q) && elg_q[wb_q];
  assign zero_fire   = wb_live && (size_q[wb_q] == '0);
  assign req_valid_o = wb_live && !zero_fire && (!blk_q || retry_i);
  assign accept      = req_valid_o && req_ready_i;
  assign req_idx_o   = wb_q;
  assign req_addr_o  = addr_q[wb_q];
  assign req_data_o  = data_q[wb_q];
  assign req_size_o  = size_q[wb_q];

  assign ack_inrange = ({1'b0, ack_idx_i} < (PW+1)'(N));
  assign ack_ok      = ack_valid_i && ack_inrange && snt_q[ack_idx_i] && !dne_q[ack_idx_i];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cmask[i] = commit_valid_i && vld_q[i] && !elg_q[i] && (seq_q[i] <= commit_seq_i);
    end
    elg_c = elg_q | cmask;
    for (int i = 0; i < N; i++) begin
      smask[i] = squash_valid_i && vld_q[i] && !elg_c[i] && (seq_q[i] > squash_seq_i);
    end
    ccnt = $countones(cmask);
    scnt = $countones(smask);
  end

  always_comb begin
    done_n = dne_q;
    if (ack_ok)    done_n = done_n | (ONE << ack_idx_i);
    if (zero_fire) done_n = done_n | (ONE << wb_q);
    p = head_q;
    go = 1'b1;
    fmask = '0;
    for (int k = 0; k < N; k++) begin
      if (go && (p != tail_q) && done_n[p]) begin
        fmask = fmask | (ONE << p);
        p = nxt(p);
      end else begin
        go = 1'b0;
      end
    end
    head_n = p;
  end

  always_comb begin
    tdiff = {1'b0, tail_q} + (PW+1)'(N) - (PW+1)'(scnt);
    if (tdiff >= (PW+1)'(N)) tdiff = tdiff - (PW+1)'(N);
    if (squash_valid_i)  tail_n = PW'(tdiff);
    else if (alloc_fire) tail_n = nxt(tail_q);
    else                 tail_n = tail_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      wb_q    <= '0;
      blk_q   <= 1'b0;
      await_q <= '0;
      vld_q   <= '0;
      elg_q   <= '0;
      snt_q   <= '0;
      dne_q   <= '0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      if (zero_fire || accept) wb_q <= nxt(wb_q);
      if (req_valid_o && !req_ready_i) blk_q <= 1'b1;
      else if (accept)                 blk_q <= 1'b0;
      await_q <= await_q + CW'(ccnt) - CW'(zero_fire) - CW'(ack_ok);
      vld_q   <= (vld_q & ~fmask & ~smask) | amask;
      elg_q   <= elg_c & ~fmask & ~smask & ~amask;
      snt_q   <= (snt_q | (accept ? (ONE << wb_q) : '0)) & ~fmask & ~amask;
      dne_q   <= done_n & ~fmask & ~amask;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      addr_q[tail_q] <= alloc_addr_i;
      data_q[tail_q] <= alloc_data_i;
      size_q[tail_q] <= alloc_size_i;
      seq_q[tail_q]  <= alloc_seq_i;
    end
  end

  a_r1_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid_i && !alloc_ready_o) |=> (count_o <= $past(count_o)));

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

  a_r5_refuse_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (blocked_o && $stable(req_idx_o)));

  a_r5_quiet_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_o && !retry_i) |-> !req_valid_o);

  a_r6_await_bound: assert property (@(posedge clk) disable iff (!rst_n)
    await_o <= count_o);

  a_r8_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid_i |=> (count_o <= $past(count_o)));

endmodule

// File: tb/store_wb_queue_tb.sv
module store_wb_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW = 16, DW = 32, ZW = 4, SW = 16;
  localparam int N = DEPTH + 1;
  localparam int PW = $clog2(N);
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid_i = 0, commit_valid_i = 0, squash_valid_i = 0;
  logic req_ready_i = 1, retry_i = 0, ack_valid_i = 0;
  logic [AW-1:0] alloc_addr_i = '0;
  logic [DW-1:0] alloc_data_i = '0;
  logic [ZW-1:0] alloc_size_i = '0;
  logic [SW-1:0] alloc_seq_i = '0, commit_seq_i = '0, squash_seq_i = '0;
  logic [PW-1:0] ack_idx_i = '0;
  logic alloc_ready_o, req_valid_o, blocked_o;
  logic [PW-1:0] alloc_idx_o, req_idx_o;
  logic [AW-1:0] req_addr_o;
  logic [DW-1:0] req_data_o;
  logic [ZW-1:0] req_size_o;
  logic [CW-1:0] count_o, await_o;

  store_wb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .ZW(ZW), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid_i(alloc_valid_i), .alloc_addr_i(alloc_addr_i), .alloc_data_i(alloc_data_i),
    .alloc_size_i(alloc_size_i), .alloc_seq_i(alloc_seq_i),
    .alloc_ready_o(alloc_ready_o), .alloc_idx_o(alloc_idx_o),
    .commit_valid_i(commit_valid_i), .commit_seq_i(commit_seq_i),
    .squash_valid_i(squash_valid_i), .squash_seq_i(squash_seq_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .retry_i(retry_i),
    .req_idx_o(req_idx_o), .req_addr_o(req_addr_o), .req_data_o(req_data_o), .req_size_o(req_size_o),
    .ack_valid_i(ack_valid_i), .ack_idx_i(ack_idx_i),
    .blocked_o(blocked_o), .count_o(count_o), .await_o(await_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int slot; int addr; int data; int size; int seq;
    bit elig; bit sent; bit done;
  } ent_t;

  ent_t mq[$];
  int m_tail = 0, m_wb = 0, m_await = 0;
  bit m_blk = 0;
  int nchk = 0, nerr = 0;
  int next_seq = 30, commit_lim = 20;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle();
    bit live, zero, ereq, acc, old_full;
    #1;
    live = (m_wb < mq.size()) && mq[m_wb].elig;
    zero = live && (mq[m_wb].size == 0);
    ereq = live && !zero && (!m_blk || retry_i);
    chk("R1 alloc_ready", int'(alloc_ready_o), int'(mq.size() < DEPTH));
    chk("R1 alloc_idx", int'(alloc_idx_o), m_tail);
    chk("R7 count", int'(count_o), mq.size());
    chk("R2 await", int'(await_o), m_await);
    chk("R5 blocked", int'(blocked_o), int'(m_blk));
    chk("R3 req_valid", int'(req_valid_o), int'(ereq));
    if (ereq) begin
      chk("R3 req_idx", int'(req_idx_o), mq[m_wb].slot);
      chk("R3 req_addr", int'(req_addr_o), mq[m_wb].addr);
      chk("R3 req_data", int'(req_data_o), mq[m_wb].data);
      chk("R3 req_size", int'(req_size_o), mq[m_wb].size);
    end
    old_full = (mq.size() >= DEPTH);
    if (ack_valid_i) begin
      foreach (mq[i]) begin
        if (mq[i].slot == int'(ack_idx_i) && mq[i].sent && !mq[i].done) begin
          mq[i].done = 1; m_await--;
        end
      end
    end
    acc = ereq && req_ready_i;
    if (zero) begin mq[m_wb].done = 1; m_await--; m_wb++; end
    else if (acc) begin mq[m_wb].sent = 1; m_wb++; m_blk = 0; end
    else if (ereq) m_blk = 1;
    if (commit_valid_i) begin
      foreach (mq[i]) begin
        if (!mq[i].elig && mq[i].seq <= int'(commit_seq_i)) begin
          mq[i].elig = 1; m_await++;
        end
      end
    end
    if (squash_valid_i) begin
      while (mq.size() > 0 && !mq[$].elig && mq[$].seq > int'(squash_seq_i)) begin
        void'(mq.pop_back());
        m_tail = (m_tail + N - 1) % N;
      end
    end else if (alloc_valid_i && !old_full) begin
      ent_t e;
      e.slot = m_tail; e.addr = int'(alloc_addr_i); e.data = int'(alloc_data_i);
      e.size = int'(alloc_size_i); e.seq = int'(alloc_seq_i);
      e.elig = 0; e.sent = 0; e.done = 0;
      mq.push_back(e);
      m_tail = (m_tail + 1) % N;
    end
    while (mq.size() > 0 && mq[0].done) begin
      void'(mq.pop_front());
      m_wb--;
    end
    @(posedge clk);
    @(negedge clk);
    alloc_valid_i = 0; commit_valid_i = 0; squash_valid_i = 0;
    ack_valid_i = 0; retry_i = 0;
  endtask

  task automatic put(int seq, int size);
    alloc_valid_i = 1;
    alloc_seq_i = SW'(seq);
    alloc_addr_i = AW'(seq * 3);
    alloc_data_i = DW'(seq * 7919);
    alloc_size_i = ZW'(size);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R9 count", int'(count_o), 0);
    chk("R9 await", int'(await_o), 0);
    chk("R9 alloc_ready", int'(alloc_ready_o), 1);
    chk("R9 alloc_idx", int'(alloc_idx_o), 0);
    chk("R9 blocked", int'(blocked_o), 0);
    chk("R9 req_valid", int'(req_valid_o), 0);

    put(10, 4); cycle();
    put(11, 2); cycle();
    put(12, 0); cycle();
    put(13, 8); cycle();
    put(14, 1); cycle();
    chk("R1 full refuses", int'(count_o), 4);
    commit_valid_i = 1; commit_seq_i = 11; cycle();
    chk("R2 await after commit", int'(await_o), 2);
    cycle(); cycle(); cycle();
    ack_valid_i = 1; ack_idx_i = 1; cycle();
    chk("R7 out of order ack frees nothing", int'(count_o), 4);
    ack_valid_i = 1; ack_idx_i = 0; cycle();
    chk("R7 contiguous release", int'(count_o), 2);
    req_ready_i = 0;
    commit_valid_i = 1; commit_seq_i = 13; cycle();
    chk("R4 no request for zero size", int'(req_valid_o), 0);
    cycle();
    chk("R4 zero size freed", int'(count_o), 1);
    chk("R4 zero size await", int'(await_o), 1);
    cycle();
    chk("R5 blocked after refusal", int'(blocked_o), 1);
    req_ready_i = 1; cycle();
    req_ready_i = 0; retry_i = 1; cycle();
    chk("R5 still blocked", int'(blocked_o), 1);
    req_ready_i = 1; retry_i = 1; cycle();
    chk("R5 retry accepted", int'(blocked_o), 0);
    ack_valid_i = 1; ack_idx_i = 0; cycle();
    chk("R6 unsent ack ignored", int'(await_o), 1);
    ack_valid_i = 1; ack_idx_i = 3; cycle();
    chk("R6 ack completes", int'(count_o), 0);
    put(20, 4); cycle();
    put(21, 4); cycle();
    put(22, 4); commit_valid_i = 1; commit_seq_i = 20; cycle();
    put(23, 4); squash_valid_i = 1; squash_seq_i = 19; cycle();
    chk("R8 squash stops at eligible", int'(count_o), 1);

    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(1, 0) == 1) begin
        put(next_seq, int'($urandom_range(4, 0)));
        if (mq.size() < DEPTH) next_seq++;
      end
      if ($urandom_range(2, 0) == 0) begin
        commit_lim = commit_lim + int'($urandom_range(2, 0));
        commit_valid_i = 1; commit_seq_i = SW'(commit_lim);
      end
      if ($urandom_range(15, 0) == 0) begin
        squash_valid_i = 1; squash_seq_i = SW'(commit_lim + int'($urandom_range(2, 0)));
        if (alloc_valid_i && mq.size() < DEPTH) next_seq--;
      end
      ack_valid_i = $urandom_range(1, 0) == 1;
      ack_idx_i = PW'($urandom_range(7, 0));
      req_ready_i = $urandom_range(3, 0) != 0;
      retry_i = $urandom_range(2, 0) == 0;
      cycle();
    end

    req_ready_i = 1;
    for (int c = 0; c < 100; c++) begin
      commit_valid_i = 1; commit_seq_i = SW'(next_seq);
      ack_valid_i = 1; ack_idx_i = PW'(c % N);
      retry_i = 1;
      cycle();
    end
    chk("R7 drained", int'(count_o), 0);
    chk("R6 await drained", int'(await_o), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule